// File: doc/BRIEF.md
# Character LCD Audio Level Meter

This block turns a stream of signed audio samples into a coarse bar-style level indication on a two-line character LCD. The LCD is written over a 4-bit data bus with separate register-select, read/write and enable lines. The block only writes to the display and never polls it. All of its pacing comes from fixed cycle counts, set by parameters for the clock in use.

After reset the block waits for the display's power-up time. It then runs an endless loop of passes. Each pass does the following, in order:

- Places the display in 4-bit, two-line mode, with the display and a blinking cursor on, address increment and no display shift.
- Waits for one valid sample and classifies its magnitude into one of eight equal ranges.
- Points the display address at the line that the range selects.
- Writes a row of solid-block characters whose length grows with the range.
- Clears the screen and starts the next pass from initialization.

Top module: `lcd_level_meter`

## Requirements
- R1: Every byte goes out as two nibbles on `lcd_d`, upper nibble first, each latched by its own enable pulse. The only exception is the first transfer of each pass, which is a lone nibble 0x2 that switches the display to the 4-bit interface.
- R2: `lcd_rs` is 1 during character transfers and 0 during instruction transfers.
- R3: `lcd_rw` is 0 at every enable pulse, so every transfer is a write.
- R4: Each pass starts with the lone nibble 0x2, followed by these instruction bytes in this order:
  - 0x28 (4-bit interface, two lines)
  - 0x0F (display on, cursor on, cursor blink)
  - 0x06 (address increment, no display shift)
- R5: The sample is two's complement, SAMPLE_W bits wide. Its magnitude is saturated to 2^(SAMPLE_W-1)-1, and the range is that magnitude shifted right by SAMPLE_W-4, giving a value from 0 to 7.
- R6: After the range decision the block sends the address instruction. It is 0x80 (line 0) for ranges 0 to 3 and 0xC0 (line 1) for ranges 4 to 7.
- R7: After the address instruction the block writes exactly range+1 character bytes of value 0xFF, all with `lcd_rs`=1.
- R8: After the characters the block sends the clear instruction 0x01. The next pass then starts again with the R4 sequence, without the power-up wait.
- R9: On every enable pulse, `lcd_d` and `lcd_rs` hold the same value from at least SETUP_CYC cycles before the enable rise until the enable falls. Enable stays high for at least EN_HIGH_CYC cycles.
- R10: Enable rises are spaced by minimum gaps:
  - At least EN_HIGH_CYC+CMD_WAIT_CYC cycles after the rise that ends a byte or the lone nibble.
  - At least EN_HIGH_CYC+CLR_WAIT_CYC cycles after the rise that ends the clear instruction.
  - The first rise after reset release comes no sooner than PWR_WAIT_CYC cycles.
- R11: The block takes a sample only in the range-decision step, on a cycle where `sample_valid` is 1, and it stays in that step until such a cycle comes. A valid strobe at any other time has no effect on the address or the character count.
- R12: While reset is held, `lcd_e` and `lcd_rw` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | SAMPLE_W | Signed audio sample |
| sample_valid | input | 1 | Marks `sample` as valid on this cycle |
| lcd_rs | output | 1 | Register select: 1 for character, 0 for instruction |
| lcd_rw | output | 1 | Read/write select, held at 0 (write) |
| lcd_e | output | 1 | Enable strobe that latches a nibble |
| lcd_d | output | 4 | Nibble data bus |

## Verification
The bench sweeps every 8-bit sample value, including the most negative code. A design that computes the magnitude without saturating would fold -128 into range 0 and write a single block on line 0 instead of eight on line 1. Range boundaries such as 15/16 and 63/64 expose off-by-one shifts, because the block count and the line change at those points.

A misleading valid strobe is given while the last initialization byte is still in flight, and another during the clear. A design that samples outside the decision step would then take the wrong value, and the following address or block count would be visibly wrong. Every enable edge is timed against the preceding data change and the preceding byte. This catches a missing clear wait, a nibble that moves while enable is high, and a first command issued before the power-up time.

// File: rtl/lcd_level_meter.sv
module lcd_level_meter #(
  parameter int SAMPLE_W     = 16,
  parameter int SETUP_CYC    = 5,
  parameter int EN_HIGH_CYC  = 30,
  parameter int CMD_WAIT_CYC = 5000,
  parameter int CLR_WAIT_CYC = 205000,
  parameter int PWR_WAIT_CYC = 1875000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                sample_valid,
  output logic                lcd_rs,
  output logic                lcd_rw,
  output logic                lcd_e,
  output logic [3:0]          lcd_d
);

  localparam int CW = $clog2(PWR_WAIT_CYC + CLR_WAIT_CYC + CMD_WAIT_CYC + EN_HIGH_CYC + SETUP_CYC + 2);
  localparam logic [7:0] OP_MODE4 = 8'h20;
  localparam logic [7:0] OP_FUNC  = 8'h28;
  localparam logic [7:0] OP_DISP  = 8'h0F;
  localparam logic [7:0] OP_ENTRY = 8'h06;
  localparam logic [7:0] OP_CLEAR = 8'h01;
  localparam logic [7:0] OP_ADDR  = 8'h80;
  localparam logic [7:0] OP_LINE1 = 8'h40;
  localparam logic [7:0] CH_BLOCK = 8'hFF;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD, PH_WAIT} phase_t;
  typedef enum logic [2:0] {ST_INIT, ST_DECIDE, ST_ADDR, ST_WRITE, ST_CLEAR} state_t;

  phase_t        ph;
  state_t        st;
  logic [CW-1:0] cnt;
  logic [7:0]    tx, nb;
  logic          tx_rs, tx_lone, tx_long, low_half;
  logic          go, nrs, nlone, nlong;
  logic [1:0]    step;
  logic [2:0]    rng, rng_in;
  logic [3:0]    left;
  logic [SAMPLE_W-1:0] mag;

  assign mag    = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
  assign rng_in = mag[SAMPLE_W-1] ? 3'd7 : mag[SAMPLE_W-2 -: 3];

  always_comb begin
    go = 1'b1; nb = OP_FUNC; nrs = 1'b0; nlone = 1'b0; nlong = 1'b0;
    case (st)
      ST_INIT: case (step)
        2'd0:    begin nb = OP_MODE4; nlone = 1'b1; end
        2'd1:    nb = OP_FUNC;
        2'd2:    nb = OP_DISP;
        default: nb = OP_ENTRY;
      endcase
      ST_DECIDE: go = 1'b0;
      ST_ADDR:   nb = OP_ADDR | (rng[2] ? OP_LINE1 : 8'h00);
      ST_WRITE:  begin nb = CH_BLOCK; nrs = 1'b1; end
      default:   begin nb = OP_CLEAR; nlong = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_WAIT; cnt <= CW'(PWR_WAIT_CYC - 1);
      st <= ST_INIT; step <= 2'd0; rng <= 3'd0; left <= 4'd0;
      tx <= 8'h00; tx_rs <= 1'b0; tx_lone <= 1'b0; tx_long <= 1'b0; low_half <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (go) begin
            tx <= nb; tx_rs <= nrs; tx_lone <= nlone; tx_long <= nlong;
            low_half <= 1'b0; ph <= PH_SETUP; cnt <= CW'(SETUP_CYC - 1);
          end
          case (st)
            ST_INIT: begin
              step <= step + 2'd1;
              if (step == 2'd3) st <= ST_DECIDE;
            end
            ST_DECIDE: if (sample_valid) begin rng <= rng_in; st <= ST_ADDR; end
            ST_ADDR:   begin left <= {1'b0, rng} + 4'd1; st <= ST_WRITE; end
            ST_WRITE:  begin
              left <= left - 4'd1;
              if (left == 4'd1) st <= ST_CLEAR;
            end
            default:   st <= ST_INIT;
          endcase
        end
        PH_SETUP: if (cnt == '0) begin ph <= PH_HIGH; cnt <= CW'(EN_HIGH_CYC - 1); end
                  else cnt <= cnt - 1'b1;
        PH_HIGH:  if (cnt == '0) ph <= PH_HOLD; else cnt <= cnt - 1'b1;
        PH_HOLD:  if (!low_half && !tx_lone) begin
                    low_half <= 1'b1; ph <= PH_SETUP; cnt <= CW'(SETUP_CYC - 1);
                  end else begin
                    ph <= PH_WAIT;
                    cnt <= tx_long ? CW'(CLR_WAIT_CYC - 1) : CW'(CMD_WAIT_CYC - 1);
                  end
        default:  if (cnt == '0) ph <= PH_IDLE; else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign lcd_e  = (ph == PH_HIGH);
  assign lcd_rs = tx_rs;
  assign lcd_rw = 1'b0;
  assign lcd_d  = low_half ? tx[3:0] : tx[7:4];

  AST_EN_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> $stable(lcd_d) && $stable(lcd_rs)); // R9
  AST_EN_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    lcd_e && $past(lcd_e) |-> $stable(lcd_d) && $stable(lcd_rs)); // R9
  AST_CHAR_ONLY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    lcd_e && lcd_rs |-> lcd_d == 4'hF); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    left <= 4'd8); // R7
  AST_SAMPLE_GATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rng) |-> $past(st == ST_DECIDE && ph == PH_IDLE && sample_valid)); // R11
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (rst)
    $past(st) == ST_CLEAR && st != ST_CLEAR |-> st == ST_INIT && step == 2'd0); // R8

endmodule

// File: tb/lcd_level_meter_test.sv
module lcd_level_meter_test;
  localparam int W = 8, SU = 2, EH = 3, CMD = 8, CLR = 30, PWR = 50;

  logic clk = 1'b0, rst = 1'b1, sv = 1'b0;
  logic [W-1:0] smp = '0;
  logic lcd_rs, lcd_rw, lcd_e;
  logic [3:0] lcd_d;

  lcd_level_meter #(.SAMPLE_W(W), .SETUP_CYC(SU), .EN_HIGH_CYC(EH),
    .CMD_WAIT_CYC(CMD), .CLR_WAIT_CYC(CLR), .PWR_WAIT_CYC(PWR)) uut (
    .clk(clk), .rst(rst), .sample(smp), .sample_valid(sv),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d(lcd_d));

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, stab = 0, hcnt = 0, last_rise = 0;
  bit pe = 1'b0, done = 1'b0;
  logic [4:0] prev_bus = '0;
  logic [4:0] nq[$];
  int tq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if ({lcd_rs, lcd_d} == prev_bus) stab++; else stab = 1;
      prev_bus = {lcd_rs, lcd_d};
      if (lcd_e && !pe) begin
        nq.push_back({lcd_rs, lcd_d}); tq.push_back(cyc);
        chk(stab > SU, "R9 setup cycles before enable rise", stab - 1, SU);
        chk(lcd_rw == 1'b0, "R3 rw at enable", int'(lcd_rw), 0);
        hcnt = 0;
      end
      if (lcd_e) hcnt++;
      if (!lcd_e && pe) chk(hcnt >= EH, "R9 enable high cycles", hcnt, EH);
      pe = lcd_e;
    end
  end

  task automatic expect_nib(input bit rs, input logic [3:0] d, input int mingap, input string tag);
    logic [4:0] n; int t;
    while (nq.size() == 0) @(negedge clk);
    n = nq.pop_front(); t = tq.pop_front();
    chk(n == {rs, d}, {tag, " rs:nibble"}, int'(n), int'({rs, d}));
    if (mingap > 0) chk(t - last_rise >= mingap, {tag, " gap"}, t - last_rise, mingap);
    last_rise = t;
  endtask

  task automatic pulse(input logic [W-1:0] v);
    @(negedge clk); #1 smp = v; sv = 1'b1;
    @(negedge clk); #1 sv = 1'b0; smp = '0;
  endtask

  function automatic int exp_rng(input logic signed [W-1:0] s);
    int m;
    m = (s < 0) ? -int'(s) : int'(s);
    if (m > 127) m = 127;
    return m / 16;
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(lcd_e == 1'b0 && lcd_rw == 1'b0, "R12 reset outputs", int'({lcd_e, lcd_rw}), 0);
    #1 rst = 1'b0; last_rise = cyc;
    for (int i = 0; i < 256; i++) begin
      logic [W-1:0] s; int r; int g;
      s = W'(i); r = exp_rng(s);
      g = (i == 0) ? PWR : EH + CLR;
      expect_nib(0, 4'h2, g, (i == 0) ? "R10 power wait, R4 lone nibble" : "R8 restart R4 lone nibble");
      expect_nib(0, 4'h2, EH + CMD, "R1 R10 R4 func hi");
      expect_nib(0, 4'h8, 0, "R1 R4 func lo");
      expect_nib(0, 4'h0, EH + CMD, "R4 disp hi");
      expect_nib(0, 4'hF, 0, "R4 disp lo");
      expect_nib(0, 4'h0, EH + CMD, "R4 entry hi");
      expect_nib(0, 4'h6, 0, "R4 entry lo");
      pulse((r < 4) ? 8'h7F : 8'h00);
      repeat (EH + CMD + 6) @(negedge clk);
      pulse(s);
      expect_nib(0, (r >= 4) ? 4'hC : 4'h8, EH + CMD, "R5 R6 R11 address hi");
      expect_nib(0, 4'h0, 0, "R6 address lo");
      for (int k = 0; k <= r; k++) begin
        expect_nib(1, 4'hF, EH + CMD, "R2 R7 block hi");
        expect_nib(1, 4'hF, 0, "R7 block lo");
      end
      expect_nib(0, 4'h0, EH + CMD, "R7 R8 clear hi");
      pulse(8'h80);
      expect_nib(0, 4'h1, 0, "R8 clear lo");
    end
    expect_nib(0, 4'h2, EH + CLR, "R8 R10 final restart");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule